// File: doc/BRIEF.md
# External Bus Idle-Gap Inserter

This block sits between the access sequencer of an external bus controller and the pin logic. It remembers the last external bus cycle that was started: whether it read or wrote, which address area it hit, and whether that area is DRAM space. When a new request would follow directly behind a cycle that could still be driving the data bus, the block puts one idle state (Ti) on the bus ahead of the new cycle's T1. This keeps slow-to-release devices from colliding with the next device.

Three pairings cause a gap. The first is two reads to different areas, which is gated by `en_rd_area_gap`. The second is a write straight after a read, gated by `en_wr_gap`. The third is any non-DRAM access straight after a DRAM access, and it always applies. Both enables come from a control register elsewhere whose reset value is 1, so gaps are inserted out of reset. The requester sees the gap as a stall on `req_ready` and uses a plain valid/ready handshake. Each accepted request runs as T1 T2, or as T1 T2 T3 when `req_long` is set.

Top module: `ext_bus_idle_gap`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `bus_state` is 0 (bus idle), `bus_idle_state` is 0, and `req_ready` is 1.
- R2: `bus_state` encodes idle=0, Ti=1, T1=2, T2=3, T3=4. A request accepted (valid and ready high at a clock edge) shows T1 on the next cycle, then T2, then T3 only if `req_long` was set at acceptance.
- R3: With `en_rd_area_gap`=1, a read that directly follows a read to a different `req_area` is preceded by exactly one Ti.
- R4: A read directly following a read to the same area gets no Ti, whatever the enables. (The DRAM exit rule in R6 still applies.)
- R5: With `en_wr_gap`=1, a write that directly follows a read is preceded by exactly one Ti.
- R6: An access with `req_dram`=0 that directly follows an access with `req_dram`=1 is preceded by exactly one Ti, whatever the enables.
- R7: With both enables at 0, area-change reads and write-after-read pairs get no Ti.
- R8: When a gap is needed, `req_ready` is low in the last state of the earlier cycle. The request is accepted during Ti, and T1 follows. `bus_idle_state` is high exactly while `bus_state` is Ti.
- R9: Write-after-write and read-after-write pairs get no Ti unless R6 applies.
- R10: If the bus returned to idle for at least one state between two cycles, no Ti is added.
- R11: When several gap conditions hold for one pair, exactly one Ti is inserted.
- R12: The first access after reset gets no Ti.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | AREA_W | Address area of the request |
| req_dram | input | 1 | Request targets DRAM space |
| req_long | input | 1 | 1 = three-state cycle, 0 = two-state cycle |
| en_rd_area_gap | input | 1 | Enables the gap between reads to different areas |
| en_wr_gap | input | 1 | Enables the gap for a write after a read |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| bus_idle_state | output | 1 | Bus is in the idle state Ti |
| bus_state | output | 3 | Current bus state (encoding in R2) |

## Verification
A chain of back-to-back accesses walks through every pairing of previous and next cycle. The pairings are read/read in the same area and in different areas, write after read, write after write, read after write, and DRAM into non-DRAM, so each gap rule is shown to fire alone and the non-gap pairings are shown to stay silent. One pair sets off two rules at once, which tells a single merged Ti apart from a doubled one. A pause on the bus before an area-changing read separates a true back-to-back pair from one already spaced by idle time. A second run with both enables cleared shows that the gated rules switch off while the DRAM exit rule stays on.

// File: rtl/igap_pkg.sv
package igap_pkg;
  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_TI   = 3'd1,
    BS_T1   = 3'd2,
    BS_T2   = 3'd3,
    BS_T3   = 3'd4
  } bus_state_t;
endpackage

// File: rtl/igap_history.sv
module igap_history #(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              at_end,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_dram,
  input  logic              en_rd_area_gap,
  input  logic              en_wr_gap,
  output logic              need_gap
);
  logic              last_vld;
  logic              last_wr;
  logic [AREA_W-1:0] last_area;
  logic              last_dram;
  logic              rule_area, rule_war, rule_dram;

  // record of the cycle currently on (or last on) the bus
  always_ff @(posedge clk) begin
    if (rst) begin
      last_vld  <= 1'b0;
      last_wr   <= 1'b0;
      last_area <= '0;
      last_dram <= 1'b0;
    end else if (accept) begin
      last_vld  <= 1'b1;
      last_wr   <= req_write;
      last_area <= req_area;
      last_dram <= req_dram;
    end
  end

  always_comb begin
    rule_area = en_rd_area_gap && !last_wr && !req_write && (last_area != req_area);
    rule_war  = en_wr_gap && !last_wr && req_write;
    rule_dram = last_dram && !req_dram;
    need_gap  = at_end && req_valid && last_vld && (rule_area || rule_war || rule_dram);
  end

  p_first_no_gap_r12: assert property (@(posedge clk) disable iff (rst)
    !last_vld |-> !need_gap);
  p_same_area_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!last_wr && !req_write && last_area == req_area && !(last_dram && !req_dram)) |-> !need_gap);
  p_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    (last_wr && !(last_dram && !req_dram)) |-> !need_gap);
endmodule

// File: rtl/igap_sequencer.sv
module igap_sequencer
  import igap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_long,
  input  logic       need_gap,
  output logic       req_ready,
  output logic       at_end,
  output logic [2:0] state_o
);
  bus_state_t state_q, state_d;
  logic       long_q;
  logic       accept;

  assign at_end    = (state_q == BS_T2 && !long_q) || (state_q == BS_T3);
  assign req_ready = (state_q == BS_IDLE) || (state_q == BS_TI) || (at_end && !need_gap);
  assign accept    = req_valid && req_ready;
  assign state_o   = state_q;

  always_comb begin
    state_d = BS_IDLE;
    if (at_end) begin
      if (accept)         state_d = BS_T1;
      else if (req_valid) state_d = BS_TI;
      else                state_d = BS_IDLE;
    end else begin
      case (state_q)
        BS_IDLE, BS_TI: state_d = accept ? BS_T1 : BS_IDLE;
        BS_T1:          state_d = BS_T2;
        BS_T2:          state_d = BS_T3;
        default:        state_d = BS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BS_IDLE;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) long_q <= req_long;
    end
  end

  p_t1_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> state_q == BS_T1);
  p_t2_after_t1_r2: assert property (@(posedge clk) disable iff (rst)
    state_q == BS_T1 |=> state_q == BS_T2);
  p_ti_single_r11: assert property (@(posedge clk) disable iff (rst)
    state_q == BS_TI |=> (state_q == BS_T1 || state_q == BS_IDLE));
  p_ti_after_end_r8: assert property (@(posedge clk) disable iff (rst)
    state_q == BS_TI |-> $past(at_end));
  p_stall_mid_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    state_q == BS_T1 |-> !req_ready);
endmodule

// File: rtl/ext_bus_idle_gap.sv
module ext_bus_idle_gap #(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_dram,
  input  logic              req_long,
  input  logic              en_rd_area_gap,
  input  logic              en_wr_gap,
  output logic              req_ready,
  output logic              bus_idle_state,
  output logic [2:0]        bus_state
);
  logic need_gap;
  logic at_end;

  igap_history #(.AREA_W(AREA_W)) u_hist (
    .clk(clk), .rst(rst), .accept(req_valid && req_ready), .at_end(at_end),
    .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
    .req_dram(req_dram), .en_rd_area_gap(en_rd_area_gap), .en_wr_gap(en_wr_gap),
    .need_gap(need_gap)
  );

  igap_sequencer u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_long(req_long),
    .need_gap(need_gap), .req_ready(req_ready), .at_end(at_end), .state_o(bus_state)
  );

  assign bus_idle_state = (bus_state == igap_pkg::BS_TI);

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (bus_state == 3'd0 && req_ready));
  p_one_gap_r11: assert property (@(posedge clk) disable iff (rst)
    bus_idle_state |=> !bus_idle_state);
endmodule

// File: tb/sim_ext_bus_idle_gap.sv
`timescale 1ns/100ps
module sim_ext_bus_idle_gap;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_dram = 1'b0, req_long = 1'b0;
  logic [2:0] req_area = '0;
  logic       en_rd_area_gap = 1'b1, en_wr_gap = 1'b1;
  logic       req_ready, bus_idle_state;
  logic [2:0] bus_state;

  int n_vec = 0, n_err = 0;
  bit done = 0;
  logic [2:0] q_st[$];
  string      q_tag[$];

  // bench model of the previous access
  bit         m_vld = 0, m_wr = 0, m_dram = 0, m_idled = 1;
  logic [2:0] m_area = '0;
  logic       prev_ready = 1'b1;

  always #2 clk = ~clk;

  ext_bus_idle_gap #(.AREA_W(3)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_area(req_area), .req_dram(req_dram), .req_long(req_long),
    .en_rd_area_gap(en_rd_area_gap), .en_wr_gap(en_wr_gap),
    .req_ready(req_ready), .bus_idle_state(bus_idle_state), .bus_state(bus_state)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops the expected state for every non-idle bus state
  always @(negedge clk) begin
    #1.5;
    if (!rst && bus_state != 3'd0) begin
      if (q_st.size() == 0) check("R10 unexpected bus activity", bus_state, 3'd0);
      else begin
        string t;
        logic [2:0] e;
        e = q_st.pop_front();
        t = q_tag.pop_front();
        check(t, bus_state, e);
      end
      check("R8 idle flag", {2'b0, bus_idle_state}, {2'b0, bus_state == 3'd1});
      if (bus_state == 3'd1) begin
        check("R8 stall before Ti", {2'b0, prev_ready}, 3'd0);
        check("R8 accept in Ti", {2'b0, req_ready}, 3'd1);
      end
    end
    prev_ready = req_ready;
  end

  task automatic issue(input logic wr, input logic [2:0] ar, input logic dr,
                       input logic lg, input string tag);
    bit gap;
    gap = m_vld && !m_idled &&
          ((en_rd_area_gap && !m_wr && !wr && m_area != ar) ||
           (en_wr_gap && !m_wr && wr) || (m_dram && !dr));
    if (gap) begin q_st.push_back(3'd1); q_tag.push_back(tag); end
    q_st.push_back(3'd2); q_tag.push_back(tag);
    q_st.push_back(3'd3); q_tag.push_back(tag);
    if (lg) begin q_st.push_back(3'd4); q_tag.push_back(tag); end
    req_valid = 1'b1; req_write = wr; req_area = ar; req_dram = dr; req_long = lg;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_vld = 1; m_wr = wr; m_area = ar; m_dram = dr; m_idled = 0;
  endtask

  task automatic idle_bus();
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    m_idled = 1;
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 state in reset", bus_state, 3'd0);
    check("R1 ready in reset", {2'b0, req_ready}, 3'd1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R1 state after reset", bus_state, 3'd0);
    check("R1 idle flag after reset", {2'b0, bus_idle_state}, 3'd0);
    check("R1 ready after reset", {2'b0, req_ready}, 3'd1);
    @(negedge clk);
    issue(1'b0, 3'd1, 1'b0, 1'b0, "R12 first read");
    issue(1'b0, 3'd1, 1'b0, 1'b1, "R4 same-area read");
    issue(1'b0, 3'd2, 1'b0, 1'b0, "R3 area-change read");
    issue(1'b1, 3'd2, 1'b0, 1'b0, "R5 write after read");
    issue(1'b1, 3'd3, 1'b0, 1'b1, "R9 write after write");
    issue(1'b0, 3'd3, 1'b0, 1'b0, "R9 read after write");
    issue(1'b0, 3'd3, 1'b1, 1'b0, "R4 same-area read into DRAM");
    issue(1'b1, 3'd3, 1'b0, 1'b0, "R11 write after DRAM read");
    issue(1'b1, 3'd4, 1'b1, 1'b0, "R9 write into DRAM");
    issue(1'b1, 3'd4, 1'b0, 1'b1, "R6 leave DRAM");
    issue(1'b0, 3'd0, 1'b0, 1'b0, "R2 short read");
    idle_bus();
    issue(1'b0, 3'd6, 1'b0, 1'b0, "R10 read after idle");
    issue(1'b0, 3'd5, 1'b0, 1'b1, "R3 area-change long read");
    en_rd_area_gap = 1'b0;
    en_wr_gap = 1'b0;
    issue(1'b0, 3'd1, 1'b0, 1'b0, "R7 area change disabled");
    issue(1'b1, 3'd1, 1'b0, 1'b0, "R7 write after read disabled");
    issue(1'b0, 3'd2, 1'b1, 1'b0, "R7 DRAM read");
    issue(1'b0, 3'd3, 1'b0, 1'b0, "R6 leave DRAM with enables off");
    idle_bus();
    check("R2 all expected states seen", q_st.size() == 0 ? 3'd0 : 3'd1, 3'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule